// File: doc/BRIEF.md
# 65816 Effective Address Generator

This block works out the 24-bit target address for every operand addressing mode of a 16-bit 6502-family processor. The sequencer presents a mode code, the access kind, up to three operand bytes that follow the opcode, and the current register values: direct page, stack pointer, the X and Y index registers, the data and program bank registers, the program counter and the emulation flag. It then pulses `start`. Indirect modes need a pointer from memory. For those, the block reads two or three bytes, one byte at a time, through a request/acknowledge port. It then returns the final address, the program counter advanced past the operand, and the open-bus byte. The open-bus byte is the value the data bus last carried.

All inputs are captured on the accepted `start`, so the caller may change them while the block is busy. `done` is a one-cycle pulse. The outputs hold their values until the next completion. Direct-page pointer locations and stack-relative locations always sit in bank 0. Data-bank results may carry into the next bank. Everything is truncated to 24 bits. Pointer bytes are read at the pointer location plus 0, 1 and 2, incremented as 24-bit values.

Top module: `eaddr_unit`

## Requirements
- R1: Direct page modes, with the operand byte n. Code 4 gives (n+D) mod 2^16. Code 5 (index X) and code 6 (index Y) give (n+D+index) mod 2^16, or mod 2^8 when `emuMode` is 1. All three results lie in bank 0.
- R2: Absolute modes, with the little-endian 16-bit operand w (byte 0 low). Code 7 gives DB·2^16+w. Codes 8 and 9 add X or Y to that full 24-bit value, so a carry can reach the bank.
- R3: Long modes, with the 24-bit little-endian operand L. Code 10 gives L. Code 11 gives (L+X) mod 2^24.
- R4: Stack relative, code 20, gives (n+S) mod 2^16 in bank 0.
- R5: Direct page indirect modes read a 2-byte pointer P in bank 0. For codes 12 and 13 the pointer sits at (n+D) mod 2^16; for code 14 it sits at (n+D+X) mod 2^16. Code 12 gives DB·2^16+P, code 13 gives (DB·2^16+P+Y) mod 2^24, and code 14 gives DB·2^16+P.
- R6: Codes 15 and 16 read a 3-byte pointer Q (low, high, bank) at (n+D) mod 2^16 in bank 0. Code 15 gives Q; code 16 gives (Q+Y) mod 2^24.
- R7: Code 17 reads a 2-byte pointer at bank 0 address w and gives PB·2^16+P. Code 18 reads a 2-byte pointer at PB·2^16+((w+X) mod 2^16) and gives PB·2^16+P. Code 19 reads a 3-byte pointer at bank 0 address w and gives Q.
- R8: Code 21 reads a 2-byte pointer at (n+S) mod 2^16 and gives (DB·2^16+P+Y) mod 2^24.
- R9: Codes 0 and 1 (immediate) give PB·2^16+PC. Code 2 gives (PC+1+sign-extended n) mod 2^16 and code 3 gives (PC+2+w) mod 2^16, both with bank bits zero.
- R10: The returned PC is PC+1 for codes 0, 2, 4-6, 12-16, 20 and 21, PC+2 for codes 1, 3, 7-9 and 17-19, and PC+3 for codes 10 and 11.
- R11: Access kind encoding: 0 read, 1 write, 2 modify, 3 jump; read and modify count as reads. Non-indirect memory modes set the open-bus byte to the last operand byte, on reads only. Indirect modes set it to the last operand byte on non-reads; on reads they set it to the last pointer byte fetched. Immediate, relative and unknown codes leave it unchanged. It resets to 0.
- R12: Each transfer carries one byte. `memAddr` stays stable while `memReq` waits for `memAck`. Exactly the pointer bytes named in R5-R8 are read, in rising address order.
- R13: `done` lasts one cycle for each accepted `start`. A `start` is accepted only while idle, which includes the cycle in which `done` is high. A `start` while busy is ignored.
- R14: Codes 22-31 perform no transfer and give address 0 with the PC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation |
| mode | input | 5 | Addressing mode code |
| access | input | 2 | Access kind |
| opByte0 | input | 8 | First operand byte |
| opByte1 | input | 8 | Second operand byte |
| opByte2 | input | 8 | Third operand byte |
| regD | input | 16 | Direct page register |
| regS | input | 16 | Stack pointer |
| regX | input | 16 | X index |
| regY | input | 16 | Y index |
| regDb | input | 8 | Data bank |
| regPb | input | 8 | Program bank |
| regPc | input | 16 | PC at the first operand byte |
| emuMode | input | 1 | Emulation mode flag |
| memReq | output | 1 | Pointer byte request |
| memAddr | output | 24 | Pointer byte address |
| memRdata | input | 8 | Returned byte |
| memAck | input | 1 | Transfer complete |
| done | output | 1 | Result valid pulse |
| effAddr | output | 24 | Effective address |
| nextPc | output | 16 | Advanced PC |
| openBus | output | 8 | Open-bus byte |

## Verification
Two events can fall in the same cycle: a completion pulse and a new `start`. Usually the bench raises the next `start` in the very cycle where it sees `done`. Each such request must be accepted, and the next result must be correct. The bench also injects extra `start` pulses with a junk mode while a pointer fetch or the final cycle is still running. It judges these by checking that the result, the PC, the open-bus byte and the list of fetched addresses all still match the model of the original request. Acknowledge delays vary at random, so these collisions land in every phase of the fetch.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 5;
  localparam int PTR_MAX = 3;
  localparam int IDX_W = $clog2(PTR_MAX + 1);

  localparam logic [MODE_W-1:0] MD_IMM8   = 5'd0;
  localparam logic [MODE_W-1:0] MD_IMM16  = 5'd1;
  localparam logic [MODE_W-1:0] MD_REL8   = 5'd2;
  localparam logic [MODE_W-1:0] MD_REL16  = 5'd3;
  localparam logic [MODE_W-1:0] MD_DP     = 5'd4;
  localparam logic [MODE_W-1:0] MD_DPX    = 5'd5;
  localparam logic [MODE_W-1:0] MD_DPY    = 5'd6;
  localparam logic [MODE_W-1:0] MD_ABS    = 5'd7;
  localparam logic [MODE_W-1:0] MD_ABSX   = 5'd8;
  localparam logic [MODE_W-1:0] MD_ABSY   = 5'd9;
  localparam logic [MODE_W-1:0] MD_LNG    = 5'd10;
  localparam logic [MODE_W-1:0] MD_LNGX   = 5'd11;
  localparam logic [MODE_W-1:0] MD_DPI    = 5'd12;
  localparam logic [MODE_W-1:0] MD_DPIY   = 5'd13;
  localparam logic [MODE_W-1:0] MD_DPXI   = 5'd14;
  localparam logic [MODE_W-1:0] MD_DPIL   = 5'd15;
  localparam logic [MODE_W-1:0] MD_DPILY  = 5'd16;
  localparam logic [MODE_W-1:0] MD_AI     = 5'd17;
  localparam logic [MODE_W-1:0] MD_AXI    = 5'd18;
  localparam logic [MODE_W-1:0] MD_AIL    = 5'd19;
  localparam logic [MODE_W-1:0] MD_STK    = 5'd20;
  localparam logic [MODE_W-1:0] MD_STKIY  = 5'd21;
  localparam logic [MODE_W-1:0] MD_LAST   = MD_STKIY;

  typedef enum logic [1:0] {ACC_READ, ACC_WRITE, ACC_MODIFY, ACC_JUMP} accE;

  typedef struct packed {
    logic             load;
    logic             capture;
    logic [IDX_W-1:0] byteIdx;
    logic             finish;
  } ctrlS;

  function automatic logic [IDX_W-1:0] ptrLen(input logic [MODE_W-1:0] m);
    case (m)
      MD_DPI, MD_DPIY, MD_DPXI, MD_AI, MD_AXI, MD_STKIY: ptrLen = IDX_W'(2);
      MD_DPIL, MD_DPILY, MD_AIL:                         ptrLen = IDX_W'(3);
      default:                                           ptrLen = '0;
    endcase
  endfunction

  function automatic logic [1:0] pcStep(input logic [MODE_W-1:0] m);
    case (m)
      MD_IMM8, MD_REL8, MD_DP, MD_DPX, MD_DPY, MD_DPI, MD_DPIY, MD_DPXI,
      MD_DPIL, MD_DPILY, MD_STK, MD_STKIY:                   pcStep = 2'd1;
      MD_IMM16, MD_REL16, MD_ABS, MD_ABSX, MD_ABSY, MD_AI,
      MD_AXI, MD_AIL:                                        pcStep = 2'd2;
      MD_LNG, MD_LNGX:                                       pcStep = 2'd3;
      default:                                               pcStep = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/eaddr_ctrl.sv
module eaddr_ctrl
  import eaddr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic              memAck,
  output logic              memReq,
  output ctrlS              ctrl
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WRAP} stateE;

  stateE            state;
  logic [IDX_W-1:0] byteCnt;
  logic [IDX_W-1:0] lenQ;
  logic [IDX_W-1:0] acksSeen;

  always_comb begin
    ctrl         = '0;
    ctrl.byteIdx = byteCnt;
    ctrl.load    = (state == ST_IDLE) && start;
    ctrl.capture = (state == ST_FETCH) && memAck;
    ctrl.finish  = (state == ST_WRAP);
    memReq       = (state == ST_FETCH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteCnt <= '0;
      lenQ    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          lenQ    <= ptrLen(mode);
          byteCnt <= '0;
          state   <= (ptrLen(mode) != '0) ? ST_FETCH : ST_WRAP;
        end
        ST_FETCH: if (memAck) begin
          if (byteCnt == lenQ - IDX_W'(1)) state <= ST_WRAP;
          else byteCnt <= byteCnt + IDX_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // count of completed transfers per request, for the check below
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acksSeen <= '0;
    else if (ctrl.load) acksSeen <= '0;
    else if (ctrl.capture) acksSeen <= acksSeen + IDX_W'(1);
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);
  assert_fetch_count_R12: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.finish |-> acksSeen == lenQ);
  assert_busy_ignore_R13: assert property (@(posedge clk) disable iff (!rstN)
    start && state != ST_IDLE |=> state != ST_IDLE || $past(state) == ST_WRAP);
endmodule

// File: rtl/eaddr_dpath.sv
module eaddr_dpath
  import eaddr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlS              ctrl,
  input  logic [MODE_W-1:0] mode,
  input  logic [1:0]        access,
  input  logic [BYTE_W-1:0] opByte0,
  input  logic [BYTE_W-1:0] opByte1,
  input  logic [BYTE_W-1:0] opByte2,
  input  logic [WORD_W-1:0] regD,
  input  logic [WORD_W-1:0] regS,
  input  logic [WORD_W-1:0] regX,
  input  logic [WORD_W-1:0] regY,
  input  logic [BYTE_W-1:0] regDb,
  input  logic [BYTE_W-1:0] regPb,
  input  logic [WORD_W-1:0] regPc,
  input  logic              emuMode,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic [WORD_W-1:0] nextPc,
  output logic [BYTE_W-1:0] openBus
);
  logic [MODE_W-1:0] modeQ;
  logic [1:0]        accQ;
  logic [ADDR_W-1:0] opndQ;
  logic [WORD_W-1:0] dQ, sQ, xQ, yQ, pcQ;
  logic [BYTE_W-1:0] dbQ, pbQ;
  logic              emuQ;
  logic [ADDR_W-1:0] ptrW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0; accQ <= '0; opndQ <= '0; emuQ <= 1'b0;
      dQ <= '0; sQ <= '0; xQ <= '0; yQ <= '0; pcQ <= '0; dbQ <= '0; pbQ <= '0;
    end else if (ctrl.load) begin
      modeQ <= mode; accQ <= access; opndQ <= {opByte2, opByte1, opByte0};
      emuQ <= emuMode; dQ <= regD; sQ <= regS; xQ <= regX; yQ <= regY;
      pcQ <= regPc; dbQ <= regDb; pbQ <= regPb;
    end
  end

  // one capture lane per pointer byte
  for (genvar g = 0; g < PTR_MAX; g++) begin : gLane
    logic [BYTE_W-1:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) laneQ <= '0;
      else if (ctrl.load) laneQ <= '0;
      else if (ctrl.capture && ctrl.byteIdx == IDX_W'(g)) laneQ <= memRdata;
    end
    assign ptrW[g*BYTE_W +: BYTE_W] = laneQ;
  end

  logic [BYTE_W-1:0] op8;
  logic [WORD_W-1:0] op16, dpBase, dpX, dpY, stkLoc, pcAfter;
  logic [ADDR_W-1:0] ptrBase, dbWord, addrC;
  logic [1:0]        step;
  logic [IDX_W-1:0]  len;
  logic              isRd;
  logic [BYTE_W-1:0] lastOp, obC;

  always_comb begin
    op8     = opndQ[BYTE_W-1:0];
    op16    = opndQ[WORD_W-1:0];
    dpBase  = dQ + {8'h00, op8};
    dpX     = dpBase + xQ;
    dpY     = dpBase + yQ;
    stkLoc  = sQ + {8'h00, op8};
    step    = pcStep(modeQ);
    len     = ptrLen(modeQ);
    pcAfter = pcQ + {14'b0, step};
    dbWord  = {dbQ, ptrW[WORD_W-1:0]};

    case (modeQ)
      MD_DPXI:  ptrBase = {8'h00, dpX};
      MD_AI,
      MD_AIL:   ptrBase = {8'h00, op16};
      MD_AXI:   ptrBase = {pbQ, op16 + xQ};
      MD_STKIY: ptrBase = {8'h00, stkLoc};
      default:  ptrBase = {8'h00, dpBase};
    endcase
    memAddr = ptrBase + ADDR_W'(ctrl.byteIdx);

    case (modeQ)
      MD_IMM8, MD_IMM16: addrC = {pbQ, pcQ};
      MD_REL8:  addrC = {8'h00, pcAfter + {{8{op8[7]}}, op8}};
      MD_REL16: addrC = {8'h00, pcAfter + op16};
      MD_DP:    addrC = {8'h00, dpBase};
      MD_DPX:   addrC = emuQ ? {16'h0000, dpX[7:0]} : {8'h00, dpX};
      MD_DPY:   addrC = emuQ ? {16'h0000, dpY[7:0]} : {8'h00, dpY};
      MD_ABS:   addrC = {dbQ, op16};
      MD_ABSX:  addrC = {dbQ, op16} + {8'h00, xQ};
      MD_ABSY:  addrC = {dbQ, op16} + {8'h00, yQ};
      MD_LNG:   addrC = opndQ;
      MD_LNGX:  addrC = opndQ + {8'h00, xQ};
      MD_DPI, MD_DPXI: addrC = dbWord;
      MD_DPIY, MD_STKIY: addrC = dbWord + {8'h00, yQ};
      MD_DPIL, MD_AIL: addrC = ptrW;
      MD_DPILY: addrC = ptrW + {8'h00, yQ};
      MD_AI, MD_AXI: addrC = {pbQ, ptrW[WORD_W-1:0]};
      MD_STK:   addrC = {8'h00, stkLoc};
      default:  addrC = '0;
    endcase

    isRd   = (accQ == ACC_READ) || (accQ == ACC_MODIFY);
    lastOp = (step == 2'd3) ? opndQ[23:16] : (step == 2'd2) ? opndQ[15:8] : op8;
    obC    = openBus;
    if (len != '0) begin
      if (!isRd) obC = lastOp;
      else obC = (len == IDX_W'(3)) ? ptrW[23:16] : ptrW[15:8];
    end else if (modeQ >= MD_DP && modeQ <= MD_STK && isRd) begin
      obC = lastOp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done <= 1'b0; effAddr <= '0; nextPc <= '0; openBus <= '0;
    end else begin
      done <= ctrl.finish;
      if (ctrl.finish) begin
        effAddr <= addrC;
        nextPc  <= pcAfter;
        openBus <= obC;
      end
    end
  end

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_unknown_zero_R14: assert property (@(posedge clk) disable iff (!rstN)
    done && modeQ > MD_LAST |-> effAddr == '0 && nextPc == pcQ);
  assert_bank_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    done && (modeQ == MD_DP || modeQ == MD_DPX || modeQ == MD_DPY || modeQ == MD_STK)
    |-> effAddr[23:16] == 8'h00);
  assert_ob_keep_R11: assert property (@(posedge clk) disable iff (!rstN)
    done && modeQ <= MD_REL16 |-> openBus == $past(openBus));
endmodule

// File: rtl/eaddr_unit.sv
module eaddr_unit
  import eaddr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [4:0]        mode,
  input  logic [1:0]        access,
  input  logic [7:0]        opByte0,
  input  logic [7:0]        opByte1,
  input  logic [7:0]        opByte2,
  input  logic [15:0]       regD,
  input  logic [15:0]       regS,
  input  logic [15:0]       regX,
  input  logic [15:0]       regY,
  input  logic [7:0]        regDb,
  input  logic [7:0]        regPb,
  input  logic [15:0]       regPc,
  input  logic              emuMode,
  output logic              memReq,
  output logic [23:0]       memAddr,
  input  logic [7:0]        memRdata,
  input  logic              memAck,
  output logic              done,
  output logic [23:0]       effAddr,
  output logic [15:0]       nextPc,
  output logic [7:0]        openBus
);
  ctrlS ctrl;

  eaddr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .memAck(memAck), .memReq(memReq), .ctrl(ctrl)
  );

  eaddr_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .mode(mode), .access(access),
    .opByte0(opByte0), .opByte1(opByte1), .opByte2(opByte2),
    .regD(regD), .regS(regS), .regX(regX), .regY(regY),
    .regDb(regDb), .regPb(regPb), .regPc(regPc), .emuMode(emuMode),
    .memRdata(memRdata), .memAddr(memAddr), .done(done),
    .effAddr(effAddr), .nextPc(nextPc), .openBus(openBus)
  );

  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr));
  assert_no_req_done_R13: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);
endmodule

// File: tb/eaddr_unit_bench.sv
module eaddr_unit_bench;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [4:0] mode = '0;
  logic [1:0] access = '0;
  logic [7:0] opByte0 = '0, opByte1 = '0, opByte2 = '0, regDb = '0, regPb = '0;
  logic [15:0] regD = '0, regS = '0, regX = '0, regY = '0, regPc = '0;
  logic emuMode = 1'b0;
  logic memReq, memAck = 1'b0, done;
  logic [23:0] memAddr, effAddr;
  logic [7:0] memRdata = '0, openBus;
  logic [15:0] nextPc;

  int checks = 0, errors = 0;
  int fetchCnt = 0, waitLeft = 0;
  logic [23:0] fetchLog [4];
  logic [7:0] obModel = 8'h00;

  always #10 clk = ~clk;

  eaddr_unit u_eaddr_unit (.*);

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ {a[19:16], a[23:20]} ^ 8'hA5;
  endfunction

  // memory responder with random acknowledge delay
  initial begin
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
        waitLeft = $urandom_range(0, 3);
      end else if (memReq) begin
        if (waitLeft == 0) begin
          memAck = 1'b1;
          memRdata = memByte(memAddr);
          if (fetchCnt < 4) fetchLog[fetchCnt] = memAddr;
          fetchCnt++;
        end else waitLeft--;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [4:0] m, input logic [1:0] acc, input logic [7:0] o0, o1, o2,
                       input logic [15:0] d, s, x, y, input logic [7:0] db, pb,
                       input logic [15:0] pc, input logic emu, input bit noise);
    logic [23:0] loc, ea;
    logic [15:0] w, pcA, p16;
    logic [23:0] q;
    int step, len, n;
    bit rd;
    string rq;
    w = {o1, o0};
    step = (m inside {0, 2, 4, 5, 6, 12, 13, 14, 15, 16, 20, 21}) ? 1 :
           (m inside {1, 3, 7, 8, 9, 17, 18, 19}) ? 2 : (m inside {10, 11}) ? 3 : 0;
    len = (m inside {12, 13, 14, 17, 18, 21}) ? 2 : (m inside {15, 16, 19}) ? 3 : 0;
    pcA = pc + 16'(step);
    case (m)
      14: loc = {8'h00, 16'(d + x + 16'(o0))};
      17, 19: loc = {8'h00, w};
      18: loc = {pb, 16'(w + x)};
      21: loc = {8'h00, 16'(s + 16'(o0))};
      default: loc = {8'h00, 16'(d + 16'(o0))};
    endcase
    p16 = {memByte(loc + 24'd1), memByte(loc)};
    q = {memByte(loc + 24'd2), p16};
    rq = "R14";
    case (m)
      0, 1: begin ea = {pb, pc}; rq = "R9"; end
      2: begin ea = {8'h00, 16'(pcA + {{8{o0[7]}}, o0})}; rq = "R9"; end
      3: begin ea = {8'h00, 16'(pcA + w)}; rq = "R9"; end
      4: begin ea = {8'h00, 16'(d + 16'(o0))}; rq = "R1"; end
      5, 6: begin
        ea = {8'h00, 16'(d + 16'(o0) + ((m == 5) ? x : y))};
        if (emu) ea = {16'h0, ea[7:0]};
        rq = "R1";
      end
      7: begin ea = {db, w}; rq = "R2"; end
      8, 9: begin ea = {db, w} + {8'h00, (m == 8) ? x : y}; rq = "R2"; end
      10: begin ea = {o2, w}; rq = "R3"; end
      11: begin ea = {o2, w} + {8'h00, x}; rq = "R3"; end
      12, 14: begin ea = {db, p16}; rq = "R5"; end
      13: begin ea = {db, p16} + {8'h00, y}; rq = "R5"; end
      15: begin ea = q; rq = "R6"; end
      16: begin ea = q + {8'h00, y}; rq = "R6"; end
      17, 18: begin ea = {pb, p16}; rq = "R7"; end
      19: begin ea = q; rq = "R7"; end
      20: begin ea = {8'h00, 16'(s + 16'(o0))}; rq = "R4"; end
      21: begin ea = {db, p16} + {8'h00, y}; rq = "R8"; end
      default: ea = 24'h0;
    endcase
    rd = (acc == 2'd0) || (acc == 2'd2);
    if (len != 0) obModel = rd ? ((len == 3) ? q[23:16] : p16[15:8]) : ((step == 2) ? o1 : o0);
    else if (m >= 4 && m <= 20 && rd) obModel = (step == 3) ? o2 : (step == 2) ? o1 : o0;

    mode = m; access = acc; opByte0 = o0; opByte1 = o1; opByte2 = o2;
    regD = d; regS = s; regX = x; regY = y; regDb = db; regPb = pb; regPc = pc; emuMode = emu;
    fetchCnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      if (noise && $urandom_range(0, 2) == 0) begin start = 1'b1; mode = 5'd20 ^ m; end
      @(negedge clk);
      start = 1'b0; mode = m; n++;
    end
    check("R13", "done seen", {31'b0, done}, 32'd1);
    check(rq, "effective address", {8'h0, effAddr}, {8'h0, ea});
    check((step == 0) ? "R14" : "R10", "next pc", {16'h0, nextPc}, {16'h0, (step == 0) ? pc : pcA});
    check("R11", "open bus", {24'h0, openBus}, {24'h0, obModel});
    check("R12", "fetch count", 32'(fetchCnt), 32'(len));
    for (int i = 0; i < len && i < fetchCnt; i++)
      check("R12", "fetch address", {8'h0, fetchLog[i]}, {8'h0, loc + 24'(i)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    check("R13", "reset done", {31'b0, done}, 32'd0);
    check("R12", "reset req", {31'b0, memReq}, 32'd0);
    check("R11", "reset open bus", {24'h0, openBus}, 32'd0);
    check("R14", "reset address", {8'h0, effAddr}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    runOp(5, 0, 8'hF0, 0, 0, 16'h12F0, 0, 16'h0030, 0, 8'h7E, 0, 16'h8000, 1, 0); // R1 emu wrap
    runOp(6, 0, 8'hFF, 0, 0, 16'hFFF0, 0, 0, 16'h0020, 0, 0, 16'h8000, 0, 0);     // R1 16-bit wrap
    runOp(8, 1, 8'hFF, 8'hFF, 0, 0, 0, 16'h0002, 0, 8'h12, 0, 16'h1000, 0, 0);   // R2 bank carry
    runOp(11, 0, 8'hFF, 8'hFF, 8'hFF, 0, 0, 16'h0005, 0, 0, 0, 16'h2000, 0, 0);  // R3 24-bit wrap
    runOp(14, 0, 8'h10, 0, 0, 16'hFFF8, 0, 16'h0010, 0, 8'h33, 0, 16'h3000, 0, 0); // R5 loc wrap
    runOp(2, 3, 8'h80, 0, 0, 0, 0, 0, 0, 0, 8'h44, 16'h0010, 0, 0);              // R9 negative wrap
    runOp(21, 2, 8'h04, 0, 0, 0, 16'h01FA, 0, 16'hFFFF, 8'hFF, 0, 16'h4000, 0, 0); // R8 24-bit wrap
    runOp(16, 1, 8'h20, 0, 0, 16'h0300, 0, 0, 16'h8000, 0, 0, 16'h5000, 0, 0);   // R6 write
    runOp(19, 3, 8'hFE, 8'hFF, 0, 0, 0, 0, 0, 0, 8'h01, 16'h6000, 0, 0);         // R7 pointer at FFFE
    runOp(5'd31, 0, 8'h11, 8'h22, 8'h33, 0, 0, 0, 0, 0, 0, 16'h7000, 0, 1);      // R14 unknown
    runOp(12, 0, 8'h40, 0, 0, 16'h0100, 0, 0, 0, 8'h05, 0, 16'h7100, 0, 1);      // R13 busy start
    // random mix, many back-to-back starts in the done cycle
    for (int k = 0; k < 600; k++) begin
      logic [4:0] m;
      m = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(22, 31)) : 5'($urandom_range(0, 21));
      runOp(m, 2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
            16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
            8'($urandom), 8'($urandom), 16'($urandom), 1'($urandom), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule